// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block sits in the feedback path of a frequency synthesiser, after a fixed divide-by-8 prescaler that is outside it. It divides the prescaled oscillator clock by a programmable ratio N = 32*M + S and emits one feedback pulse for the phase comparator every N input cycles. The local oscillator then settles at reference * 8 * N. Internally a 32/33 dual-modulus group counter runs under the control of a swallow comparison. In each output period the first S groups are 33 cycles long and the other M - S groups are 32 cycles long.

Software-side logic writes a 10-bit main value M, a 5-bit swallow value S and a 3-bit mode code, then pulses a load strobe. The mode code and the range clamp are applied when the word is captured. The captured word waits in a shadow register and is taken into use only when the running period ends, so a period is never cut short. Mode code 1 selects the narrow 14-bit ratio. In that mode bit 9 of M is dropped, which limits M to 32..511. Every other mode code keeps the full 15-bit ratio. If M comes out below 32, it is raised to 32, so that M is never smaller than S.

Top module: `divfb_main_div`

## Requirements
- R1: Consecutive rising edges of `fb_pulse` are exactly 32*M + S input clock cycles apart, where M and S are the values in use for that period.
- R2: `fb_pulse` is high for exactly one input clock cycle per output period.
- R3: S takes any value from 0 to 31. Each period starts with S groups of 33 cycles, and all later groups in that period are 32 cycles long.
- R4: When the mode code is 1 at load time, bit 9 of `m_val` is ignored and treated as zero, so M is limited to 32..511.
- R5: For mode codes 0 and 2 to 7, all 10 bits of `m_val` are used, which gives M up to 1023 and periods up to 32767 cycles.
- R6: An M value below 32, after any bit 9 masking, is used as 32.
- R7: A load during a running period does not change the length of that period. The new values take effect in the next period.
- R8: When several loads occur within one period, the values of the last load are the ones that take effect.
- R9: While `rst_n` is low, `fb_pulse` is low. After reset is released, the block runs with M = 32 and S = 0, and the first pulse follows 1024 cycles after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_div8 | input | 1 | Prescaled oscillator clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| load | input | 1 | Captures m_val, s_val and mode_sel into the shadow word |
| m_val | input | 10 | Main count M |
| s_val | input | 5 | Swallow count S |
| mode_sel | input | 3 | Step mode code; 1 selects the 14-bit ratio |
| fb_pulse | output | 1 | One-cycle feedback pulse per output period |

## Verification
Several properties are checked on every cycle. Each pulse is one cycle wide. The pulse spacing matches 32*M + S of the word in use. Long groups never follow a short group within a period. The word in use only changes on the terminal count. The captured M never falls below 32, and it never keeps bit 9 after a load in the narrow mode. Other behaviours can only be shown by the bench's stimulus sequences: the last load winning, a load in mid-period leaving that period intact, the extreme ratios 1024 and 32767, and the exact reset-to-first-pulse distance.

// File: rtl/divfb_pkg.sv
package divfb_pkg;
  localparam int unsigned M_W         = 10;  // main count width
  localparam int unsigned S_W         = 5;   // swallow count width
  localparam int unsigned MODE_W      = 3;   // step mode code width
  localparam int unsigned MIN_M       = 32;  // smallest legal main count
  localparam int unsigned NARROW_MODE = 1;   // code selecting 14-bit ratio
  localparam int unsigned GRP_W       = 6;   // holds 0..32 in the group counter

  // Total division ratio of a word, used by checkers.
  function automatic logic [M_W+S_W:0] ratio_of(input logic [M_W-1:0] m,
                                                 input logic [S_W-1:0] s);
    ratio_of = {1'b0, m, {S_W{1'b0}}} + {{(M_W+1){1'b0}}, s};
  endfunction
endpackage

// File: rtl/divfb_word_fix.sv
// Applies the mode mask on the top M bit and the lower clamp on M.
module divfb_word_fix #(
  parameter int unsigned M_W         = 10,
  parameter int unsigned S_W         = 5,
  parameter int unsigned MODE_W      = 3,
  parameter int unsigned MIN_M       = 32,
  parameter int unsigned NARROW_MODE = 1
) (
  input  logic [M_W-1:0]    m_raw,
  input  logic [S_W-1:0]    s_raw,
  input  logic [MODE_W-1:0] mode,
  output logic [M_W-1:0]    m_fix,
  output logic [S_W-1:0]    s_fix
);
  localparam logic [M_W-1:0]    MIN_M_V  = M_W'(MIN_M);
  localparam logic [MODE_W-1:0] NARROW_V = MODE_W'(NARROW_MODE);

  logic [M_W-1:0] m_masked;

  always_comb begin
    if (mode == NARROW_V) begin
      m_masked = {1'b0, m_raw[M_W-2:0]};
    end else begin
      m_masked = m_raw;
    end
    if (m_masked < MIN_M_V) begin
      m_fix = MIN_M_V;
    end else begin
      m_fix = m_masked;
    end
    s_fix = s_raw;
  end
endmodule

// File: rtl/divfb_dual_mod.sv
// 32/33 dual-modulus group counter: flags the last cycle of each group.
module divfb_dual_mod #(
  parameter int unsigned GRP_W = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mod33,
  output logic grp_end,
  output logic [GRP_W-1:0] pc
);
  localparam logic [GRP_W-1:0] LAST32 = GRP_W'(31);
  localparam logic [GRP_W-1:0] LAST33 = GRP_W'(32);

  logic [GRP_W-1:0] pc_q, pc_d;
  logic             pc_en;

  always_comb begin
    grp_end = mod33 ? (pc_q == LAST33) : (pc_q == LAST32);
    pc_en   = 1'b1;
    if (grp_end) begin
      pc_d = '0;
    end else begin
      pc_d = pc_q + GRP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else if (pc_en) begin
      pc_q <= pc_d;
    end
  end

  assign pc = pc_q;
endmodule

// File: rtl/divfb_group_ctr.sv
// Counts groups within a period; the first S groups request modulus 33.
module divfb_group_ctr #(
  parameter int unsigned M_W = 10,
  parameter int unsigned S_W = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           grp_end,
  input  logic [M_W-1:0] act_m,
  input  logic [S_W-1:0] act_s,
  output logic           mod33,
  output logic           terminal
);
  logic [M_W-1:0] mc_q, mc_d;
  logic           mc_en;
  logic [M_W-1:0] last_grp;

  always_comb begin
    last_grp = act_m - M_W'(1);
    mod33    = mc_q < {{(M_W-S_W){1'b0}}, act_s};
    terminal = grp_end && (mc_q == last_grp);
    mc_en    = grp_end;
    if (terminal) begin
      mc_d = '0;
    end else begin
      mc_d = mc_q + M_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mc_q <= '0;
    end else if (mc_en) begin
      mc_q <= mc_d;
    end
  end
endmodule

// File: rtl/divfb_main_div.sv
module divfb_main_div
  import divfb_pkg::*;
#(
  parameter int unsigned P_M_W    = M_W,
  parameter int unsigned P_S_W    = S_W,
  parameter int unsigned P_MODE_W = MODE_W,
  parameter int unsigned P_MIN_M  = MIN_M,
  parameter int unsigned P_NARROW = NARROW_MODE,
  parameter int unsigned P_GRP_W  = GRP_W
) (
  input  logic                clk_div8,
  input  logic                rst_n,
  input  logic                load,
  input  logic [P_M_W-1:0]    m_val,
  input  logic [P_S_W-1:0]    s_val,
  input  logic [P_MODE_W-1:0] mode_sel,
  output logic                fb_pulse
);
  localparam logic [P_M_W-1:0] RST_M = P_M_W'(P_MIN_M);

  logic [P_M_W-1:0]   ld_m;
  logic [P_S_W-1:0]   ld_s;
  logic [P_M_W-1:0]   pend_m, pend_m_d;
  logic [P_S_W-1:0]   pend_s, pend_s_d;
  logic [P_M_W-1:0]   act_m, act_m_d;
  logic [P_S_W-1:0]   act_s, act_s_d;
  logic               pend_en, act_en;
  logic               mod33, grp_end, terminal;
  logic [P_GRP_W-1:0] pc;
  logic               fb_q, fb_d;

  divfb_word_fix #(
    .M_W(P_M_W), .S_W(P_S_W), .MODE_W(P_MODE_W),
    .MIN_M(P_MIN_M), .NARROW_MODE(P_NARROW)
  ) u_fix (
    .m_raw(m_val), .s_raw(s_val), .mode(mode_sel),
    .m_fix(ld_m), .s_fix(ld_s)
  );

  divfb_dual_mod #(.GRP_W(P_GRP_W)) u_dm (
    .clk(clk_div8), .rst_n(rst_n), .mod33(mod33),
    .grp_end(grp_end), .pc(pc)
  );

  divfb_group_ctr #(.M_W(P_M_W), .S_W(P_S_W)) u_grp (
    .clk(clk_div8), .rst_n(rst_n), .grp_end(grp_end),
    .act_m(act_m), .act_s(act_s),
    .mod33(mod33), .terminal(terminal)
  );

  // Next-state: shadow word takes each load; active word switches on terminal.
  always_comb begin
    pend_en  = load;
    pend_m_d = ld_m;
    pend_s_d = ld_s;
    act_en   = terminal;
    if (load) begin
      act_m_d = ld_m;
      act_s_d = ld_s;
    end else begin
      act_m_d = pend_m;
      act_s_d = pend_s;
    end
    fb_d = terminal;
  end

  always_ff @(posedge clk_div8 or negedge rst_n) begin
    if (!rst_n) begin
      pend_m <= RST_M;
      pend_s <= '0;
    end else if (pend_en) begin
      pend_m <= pend_m_d;
      pend_s <= pend_s_d;
    end
  end

  always_ff @(posedge clk_div8 or negedge rst_n) begin
    if (!rst_n) begin
      act_m <= RST_M;
      act_s <= '0;
    end else if (act_en) begin
      act_m <= act_m_d;
      act_s <= act_s_d;
    end
  end

  always_ff @(posedge clk_div8 or negedge rst_n) begin
    if (!rst_n) begin
      fb_q <= 1'b0;
    end else begin
      fb_q <= fb_d;
    end
  end

  assign fb_pulse = fb_q;
endmodule

// File: rtl/divfb_main_div_chk.sv
module divfb_main_div_chk
  import divfb_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             load,
  input logic [MODE_W-1:0] mode_sel,
  input logic [M_W-1:0]   pend_m,
  input logic [M_W-1:0]   act_m,
  input logic [S_W-1:0]   act_s,
  input logic             terminal,
  input logic             grp_end,
  input logic             mod33,
  input logic [GRP_W-1:0] pc,
  input logic             fb
);
  logic [M_W+S_W:0] cnt, nexp;
  logic             seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      nexp <= '0;
      seen <= 1'b0;
    end else if (fb) begin
      cnt  <= (M_W+S_W+1)'(1);
      nexp <= ratio_of(act_m, act_s);
      seen <= 1'b1;
    end else begin
      cnt  <= cnt + (M_W+S_W+1)'(1);
    end
  end

  assert_period_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (fb && seen) |-> (cnt == nexp));

  assert_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fb |=> !fb);

  assert_long_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_end && !terminal && !mod33) |=> !mod33);

  assert_group_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pc <= GRP_W'(32));

  assert_m9_dropped_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && mode_sel == MODE_W'(NARROW_MODE)) |=> (pend_m[M_W-1] == 1'b0));

  assert_min_m_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_m >= M_W'(MIN_M)) && (pend_m >= M_W'(MIN_M)));

  assert_swap_on_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !terminal |=> ($stable(act_m) && $stable(act_s)));
endmodule

bind divfb_main_div divfb_main_div_chk u_chk (
  .clk(clk_div8), .rst_n(rst_n), .load(load), .mode_sel(mode_sel),
  .pend_m(pend_m), .act_m(act_m), .act_s(act_s), .terminal(terminal),
  .grp_end(grp_end), .mod33(mod33), .pc(pc), .fb(fb_pulse)
);

// File: tb/divfb_main_div_test.sv
`timescale 1ns/1ps
module divfb_main_div_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       load;
  logic [9:0] m_val;
  logic [4:0] s_val;
  logic [2:0] mode_sel;
  logic       fb_pulse;

  int    n_checks = 0, n_fail = 0;
  int    cyc = 0, total = 0, last = 0, pulses = 0;
  int    exp_cur, exp_pend;
  string tag_cur, tag_pend;
  bit    prev_fb = 1'b0, timed_out = 1'b0;
  localparam int WD_LIMIT = 190000;

  always #2.5 clk = ~clk;

  divfb_main_div uut (
    .clk_div8(clk), .rst_n(rst_n), .load(load), .m_val(m_val),
    .s_val(s_val), .mode_sel(mode_sel), .fb_pulse(fb_pulse)
  );

  // Ratio from the requirements: mode 1 drops M bit 9, M below 32 becomes 32.
  function automatic int ratio(input int m, input int s, input int mode);
    int mm;
    mm = (mode == 1) ? (m % 512) : (m % 1024);
    if (mm < 32) mm = 32;
    return 32 * mm + (s % 32);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    total++;
    if (total > WD_LIMIT) timed_out = 1'b1;
    if (prev_fb) check(fb_pulse == 1'b0, "R2", int'(fb_pulse), 0);
    if (fb_pulse) begin
      check(cyc - last == exp_cur, tag_cur, cyc - last, exp_cur);
      last = cyc;
      exp_cur = exp_pend;
      tag_cur = tag_pend;
      pulses++;
    end
    prev_fb = fb_pulse;
  endtask

  task automatic wait_pulse();
    int p0;
    p0 = pulses;
    while (pulses == p0 && !timed_out) step();
  endtask

  task automatic do_load(input int m, input int s, input int mode, input string tag);
    m_val = 10'(m);
    s_val = 5'(s);
    mode_sel = 3'(mode);
    load = 1'b1;
    exp_pend = ratio(m, s, mode);
    tag_pend = tag;
    step();
    load = 1'b0;
  endtask

  task automatic period_with(input int m, input int s, input int mode, input string tag);
    do_load(m, s, mode, tag);
    wait_pulse();
  endtask

  initial begin
    void'($urandom(32'd20417));
    rst_n = 1'b0;
    load = 1'b0;
    m_val = '0;
    s_val = '0;
    mode_sel = '0;
    exp_cur = 1024;
    exp_pend = 1024;
    tag_cur = "R9";
    tag_pend = "R9";
    repeat (4) @(negedge clk);
    check(fb_pulse == 1'b0, "R9", int'(fb_pulse), 0);  // R9 reset state
    rst_n = 1'b1;
    cyc = 0;
    last = 0;
    wait_pulse();  // R9: first period 1024 after release

    period_with(32, 31, 0, "R3");
    period_with(1023, 31, 0, "R5");
    period_with(1023, 31, 1, "R4");
    period_with(600, 7, 1, "R4");
    period_with(600, 7, 3, "R5");
    period_with(5, 3, 0, "R6");
    period_with(0, 0, 4, "R6");
    period_with(522, 9, 1, "R6");
    period_with(40, 0, 2, "R3");

    // R7 and R8: loads in mid-period leave it intact; the last one wins.
    period_with(70, 20, 0, "R7");
    wait_pulse();
    repeat (100) step();
    do_load(90, 1, 0, "R8");
    repeat (100) step();
    do_load(45, 13, 2, "R8");
    wait_pulse();

    for (int i = 0; i < 15; i++) begin
      period_with(32 + int'($urandom % 90), int'($urandom % 32),
                  int'($urandom % 5), "R1");
    end
    wait_pulse();
    wait_pulse();

    if (timed_out) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", total, WD_LIMIT);
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule